// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block is the slave side of a stereo serial audio link. An external bit clock and an external frame clock set the timing. The frame clock's level tells which channel is in flight. On the serial output the port sends a pair of 20-bit capture words, one per channel. From the serial input it collects a pair of playback words. Each time a full stereo frame has arrived, it presents both received words together with a one-cycle valid strobe.

The port runs on a fast system clock. It oversamples the bit clock, the frame clock and the serial input through a synchronizer, and it acts on the detected edges. Output bits move after a falling bit-clock edge. Input bits are taken at a rising edge.

A 2-bit format select picks one of four framings. The transmit and receive directions use different justification and word lengths depending on the format. In the I2S-style format the frame-clock polarity is inverted, and that format also works with only 16 bit periods per channel by dropping the low bits.

Top module: `sap_port`

## Requirements
- R1: While reset is high and in the cycle after it is released, sdout, rx_valid, rx_left and rx_right are all zero.
- R2: fmt encoding: 0 = transmit MSB-justified / receive 16-bit LSB-justified; 1 = transmit MSB-justified / receive 20-bit LSB-justified; 2 = MSB-justified both ways; 3 = I2S-style framing both ways.
- R3: In formats 0, 1 and 2, bit period k of a half-frame (k = 0 is the first period after the frame-clock transition) carries transmit-word bit 19-k, MSB first, and sdout changes only after a detected falling bit-clock edge.
- R4: In format 3, bit period 0 of a half-frame carries zero, and bit period k (1 to 20) carries transmit-word bit 20-k.
- R5: sdout is zero in every bit period after the last bit of the transmit word within the half-frame.
- R6: In formats 0 to 2, a high frame clock selects the left channel. In format 3, a low frame clock selects the left channel. A stereo frame starts with its left half.
- R7: In format 0, the last 16 bits before the frame-clock edge that ends a half-frame become bits 19:4 of the received word, bits 3:0 are zero, and earlier bits are ignored.
- R8: In format 1, the last 20 bits before the frame-clock edge that ends a half-frame form the received word, and earlier bits are ignored.
- R9: In format 2, the first 20 bits of a half-frame form the received word, and later bits are ignored.
- R10: In format 3, the received word is taken from bit periods 1 to 20. With 16 bit periods per half-frame, only bits 19:5 are sent and received, and the dropped low bits read as zero.
- R11: rx_valid is a one-cycle pulse, raised once per stereo frame after the right half ends. rx_left and rx_right change only in that cycle. The first incomplete frame after reset is not reported.
- R12: Serial input bits are taken at the rising bit-clock edge, so input that changes with the falling edge is received intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 2 | Frame format select |
| bclk | input | 1 | External bit clock |
| fclk | input | 1 | External frame (channel) clock |
| sdin | input | 1 | Serial playback data in |
| sdout | output | 1 | Serial capture data out |
| tx_left | input | 20 | Left word to transmit |
| tx_right | input | 20 | Right word to transmit |
| rx_left | output | 20 | Last received left word |
| rx_right | output | 20 | Last received right word |
| rx_valid | output | 1 | One-cycle strobe: a new received pair is on rx_left/rx_right |

## Verification
The assertions take several things as given about the inputs:
- Every bit-clock level lasts several system-clock cycles, more than the synchronizer depth plus two.
- fclk and sdin change only together with a falling bit-clock edge.
- fmt stays constant between resets.
- Each half-frame lasts at least 16 bit periods.

The stimulus holds each bit-clock level for six system cycles and drives fclk and sdin in the same cycle as the falling edge. It applies reset before each change of format and uses only the half-frame lengths that each format allows.

// File: rtl/sap_pkg.sv
package sap_pkg;
  typedef enum logic [1:0] {
    FMT_LSB16 = 2'd0,
    FMT_LSB20 = 2'd1,
    FMT_MSBJ  = 2'd2,
    FMT_I2S   = 2'd3
  } fmt_e;
endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic fclk_in,
  input  logic din_in,
  output logic rise,
  output logic fall,
  output logic fclk_q,
  output logic din_q
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] s_b, s_f, s_d;
  logic b_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_b <= '0; s_f <= '0; s_d <= '0;
      b_d <= 1'b0; rise <= 1'b0; fall <= 1'b0;
      fclk_q <= 1'b0; din_q <= 1'b0;
    end else begin
      s_b    <= {s_b[STAGES-2:0], bclk_in};
      s_f    <= {s_f[STAGES-2:0], fclk_in};
      s_d    <= {s_d[STAGES-2:0], din_in};
      b_d    <= s_b[TOP];
      rise   <= s_b[TOP] & ~b_d;
      fall   <= ~s_b[TOP] & b_d;
      fclk_q <= s_f[TOP];
      din_q  <= s_d[TOP];
    end
  end
endmodule

// File: rtl/sap_tx.sv
module sap_tx import sap_pkg::*; #(
  parameter int W  = 20,
  parameter int CW = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  fmt_e         fmt,
  input  logic         fall,
  input  logic         fclk,
  input  logic [W-1:0] tx_l,
  input  logic [W-1:0] tx_r,
  output logic         sdout
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] ONE     = CW'(1);
  localparam logic [CW-1:0] W_C     = CW'(W);

  logic          seen, prev, i2s, bnd, in_win, bit_n;
  logic [CW-1:0] cnt, cnt_n, pos;
  logic [W-1:0]  word, word_n, shifted;

  always_comb begin
    i2s = (fmt == FMT_I2S);
    bnd = seen && (fclk != prev);
    if (bnd) begin
      cnt_n  = '0;
      word_n = (fclk ^ i2s) ? tx_l : tx_r;
    end else begin
      cnt_n  = (cnt == CNT_MAX) ? cnt : cnt + ONE;
      word_n = word;
    end
    pos     = i2s ? cnt_n - ONE : cnt_n;
    in_win  = i2s ? ((cnt_n != '0) && (pos < W_C)) : (pos < W_C);
    shifted = word_n << pos;
    bit_n   = in_win & shifted[W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0; prev <= 1'b0; cnt <= CNT_MAX;
      word <= '0; sdout <= 1'b0;
    end else if (fall) begin
      seen  <= 1'b1;
      prev  <= fclk;
      cnt   <= cnt_n;
      word  <= word_n;
      sdout <= bit_n;
    end
  end

  // R3: the serial output only moves right after a falling bit-clock edge
  p_sdout_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdout) |-> $past(fall));
endmodule

// File: rtl/sap_rx.sv
module sap_rx import sap_pkg::*; #(
  parameter int W  = 20,
  parameter int SW = 16,
  parameter int CW = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  fmt_e         fmt,
  input  logic         rise,
  input  logic         fclk,
  input  logic         din,
  output logic [W-1:0] rx_l,
  output logic [W-1:0] rx_r,
  output logic         rx_valid
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] ONE     = CW'(1);
  localparam logic [CW-1:0] W_C     = CW'(W);

  logic          seen, prev, locked, have_l, i2s, bnd, prev_left, in_win;
  logic [CW-1:0] cnt, cnt_n, pos;
  logic [W-1:0]  shreg, acc, acc_base, acc_n, done_w, stage_l;

  always_comb begin
    i2s       = (fmt == FMT_I2S);
    bnd       = seen && (fclk != prev);
    prev_left = (prev != i2s);
    unique case (fmt)
      FMT_LSB16: done_w = {shreg[SW-1:0], {(W-SW){1'b0}}};
      FMT_LSB20: done_w = shreg;
      default:   done_w = acc;
    endcase
    cnt_n    = bnd ? '0 : ((cnt == CNT_MAX) ? cnt : cnt + ONE);
    acc_base = bnd ? '0 : acc;
    pos      = i2s ? cnt_n - ONE : cnt_n;
    in_win   = i2s ? ((cnt_n != '0) && (pos < W_C)) : (pos < W_C);
    acc_n    = in_win ? (acc_base | ({din, {(W-1){1'b0}}} >> pos)) : acc_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0; prev <= 1'b0; locked <= 1'b0; have_l <= 1'b0;
      cnt <= CNT_MAX; shreg <= '0; acc <= '0; stage_l <= '0;
      rx_l <= '0; rx_r <= '0; rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise) begin
        seen  <= 1'b1;
        prev  <= fclk;
        cnt   <= cnt_n;
        shreg <= {shreg[W-2:0], din};
        acc   <= acc_n;
        if (bnd) begin
          locked <= 1'b1;
          if (locked) begin
            if (prev_left) begin
              stage_l <= done_w;
              have_l  <= 1'b1;
            end else if (have_l) begin
              rx_l     <= stage_l;
              rx_r     <= done_w;
              rx_valid <= 1'b1;
              have_l   <= 1'b0;
            end
          end
        end
      end
    end
  end

  // R11: strobe lasts one cycle
  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R11: received words only change together with the strobe
  p_words_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> ($stable(rx_l) && $stable(rx_r)));
  // R7: short format leaves the low bits clear
  p_short_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && fmt == FMT_LSB16) |-> (rx_l[W-SW-1:0] == '0 && rx_r[W-SW-1:0] == '0));
endmodule

// File: rtl/sap_port.sv
module sap_port import sap_pkg::*; #(
  parameter int WORD_W        = 20,
  parameter int SHORT_W       = 16,
  parameter int MAX_HALF_BITS = 64,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmt,
  input  logic              bclk,
  input  logic              fclk,
  input  logic              sdin,
  output logic              sdout,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid
);
  localparam int CW = $clog2(MAX_HALF_BITS + 2);

  fmt_e mode;
  logic rise, fall, fclk_q, din_q;

  assign mode = fmt_e'(fmt);

  sap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk_in(bclk), .fclk_in(fclk), .din_in(sdin),
    .rise(rise), .fall(fall), .fclk_q(fclk_q), .din_q(din_q)
  );

  sap_tx #(.W(WORD_W), .CW(CW)) u_tx (
    .clk(clk), .rst(rst), .fmt(mode), .fall(fall), .fclk(fclk_q),
    .tx_l(tx_left), .tx_r(tx_right), .sdout(sdout)
  );

  sap_rx #(.W(WORD_W), .SW(SHORT_W), .CW(CW)) u_rx (
    .clk(clk), .rst(rst), .fmt(mode), .rise(rise), .fclk(fclk_q), .din(din_q),
    .rx_l(rx_left), .rx_r(rx_right), .rx_valid(rx_valid)
  );
endmodule

// File: tb/sap_port_bench.sv
module sap_port_bench;
  localparam int HALF = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] fmt = 2'd0;
  logic bclk = 1'b1, fclk = 1'b0, sdin = 1'b0;
  logic sdout, rx_valid;
  logic [19:0] tx_left = '0, tx_right = '0, rx_left, rx_right;

  int n_chk = 0, n_fail = 0, fidx = 0, vidx = 0, cyc = 0;
  logic [19:0] exp_l [64];
  logic [19:0] exp_r [64];
  int exp_m [64];
  bit finished = 0;

  always #10 clk = ~clk;

  sap_port u_sap_port (
    .clk(clk), .rst(rst), .fmt(fmt), .bclk(bclk), .fclk(fclk), .sdin(sdin),
    .sdout(sdout), .tx_left(tx_left), .tx_right(tx_right),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic rx_bit(input int m, input int n, input int k, input logic [19:0] w, input logic junk);
    case (m)
      0: return (k >= n - 16) ? w[15 - (k - (n - 16))] : junk;
      1: return (k >= n - 20) ? w[19 - (k - (n - 20))] : junk;
      2: return (k < 20) ? w[19 - k] : junk;
      default: return (k >= 1 && k <= 20) ? w[20 - k] : junk;
    endcase
  endfunction

  function automatic logic [19:0] rx_exp(input int m, input int n, input logic [19:0] w);
    case (m)
      0: return {w[15:0], 4'h0};
      3: return (n - 1 >= 20) ? w : (w & ~(20'hFFFFF >> (n - 1)));
      default: return w;
    endcase
  endfunction

  function automatic logic tx_exp(input int m, input int k, input logic [19:0] w);
    if (m == 3) return (k >= 1 && k <= 20) ? w[20 - k] : 1'b0;
    return (k < 20) ? w[19 - k] : 1'b0;
  endfunction

  task automatic send_bit(input logic fv, input logic dv, output logic so);
    @(negedge clk); bclk = 1'b0; fclk = fv; sdin = dv;
    repeat (HALF - 1) @(negedge clk);
    so = sdout;
    @(negedge clk); bclk = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic send_half(input int m, input int n, input logic lvl,
                           input logic [19:0] wtx, input logic [19:0] wrx, input bit check);
    logic [63:0] got, exp;
    logic so;
    got = '0; exp = '0;
    for (int k = 0; k < n; k++) begin
      send_bit(lvl, rx_bit(m, n, k, wrx, 1'($urandom % 2)), so);
      got[k] = so;
      exp[k] = tx_exp(m, k, wtx);
    end
    if (check)
      chk(got == exp, (m == 3) ? "R4 R6 R10 tx" : "R3 R5 R6 tx", got, exp);
  endtask

  task automatic run_seg(input int m, input int n, input int frames);
    logic rest, so;
    logic [19:0] tl, tr, rl, rr;
    rest = (m == 3) ? 1'b1 : 1'b0;
    @(negedge clk); rst = 1'b1; bclk = 1'b1; fclk = rest; fmt = 2'(m);
    tx_left = '0; tx_right = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < n; k++) send_bit(rest, 1'b0, so);
    for (int f = 0; f < frames; f++) begin
      if (f == 0) begin
        tl = 20'h80000; tr = 20'h7FFFF; rl = 20'h7FFFF; rr = 20'h80001;
      end else begin
        tl = 20'($urandom); tr = 20'($urandom); rl = 20'($urandom); rr = 20'($urandom);
      end
      exp_l[fidx] = rx_exp(m, n, rl);
      exp_r[fidx] = rx_exp(m, n, rr);
      exp_m[fidx] = m;
      fidx++;
      tx_left = tl; tx_right = tr;
      send_half(m, n, ~rest, tl, rl, 1);
      send_half(m, n, rest, tr, rr, 1);
    end
    send_half(m, n, ~rest, '0, '0, 0);
    repeat (20) @(negedge clk);
    chk(vidx == fidx, "R11 frame count", 64'(vidx), 64'(fidx));
  endtask

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (vidx >= fidx) begin
        chk(1'b0, "R11 spurious strobe", 64'(vidx), 64'(fidx));
      end else begin
        string tag;
        case (exp_m[vidx])
          0: tag = "R7";
          1: tag = "R8";
          2: tag = "R9";
          default: tag = "R10";
        endcase
        chk(rx_left == exp_l[vidx], {tag, " R2 R6 R12 rx left"}, 64'(rx_left), 64'(exp_l[vidx]));
        chk(rx_right == exp_r[vidx], {tag, " R2 R6 R12 rx right"}, 64'(rx_right), 64'(exp_r[vidx]));
      end
      vidx++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(sdout == 1'b0 && rx_valid == 1'b0, "R1 reset outputs", {62'd0, sdout, rx_valid}, 64'd0);
    chk(rx_left == '0 && rx_right == '0, "R1 reset words", {rx_left, rx_right}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(sdout == 1'b0 && rx_valid == 1'b0 && rx_left == '0, "R1 after release",
        {43'd0, rx_left, sdout}, 64'd0);
    run_seg(0, 16, 4);
    run_seg(0, 32, 4);
    run_seg(1, 20, 4);
    run_seg(1, 32, 4);
    run_seg(2, 20, 3);
    run_seg(2, 32, 4);
    run_seg(3, 16, 4);
    run_seg(3, 20, 3);
    run_seg(3, 32, 4);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule